// File: doc/BRIEF.md
# Strobed Bus Bridge into a Double-Rate Peripheral Domain

The bridge sits between a CPU bus with asynchronous control signals and a peripheral register bank. The bank runs on a clock twice as fast as the CPU. The CPU marks each access with an active-low address strobe, a chip select, two byte-lane strobes and a read/write line. It then waits for an active-low acknowledge. Before any decision is made on them, all control inputs pass through a register stage clocked by the fast clock.

Each time the registered strobe-and-select changes from inactive to active, exactly one register-bank access starts. Address, write data, direction and lane strobes are captured on that same clock. The acknowledge is driven from a register and stays asserted until the strobe is released. The next access is only recognised after the strobe has been seen inactive. A 32-bit CPU write arrives as two 16-bit cycles separated by a very short strobe gap. Both halves are detected and acknowledged, so the CPU never waits forever.

Top module: `bus_xdomain_bridge`

## Requirements
- R1: While reset is active and on the first cycle after it, `cpu_ack_n` is high. After reset every register in the bank reads 0.
- R2: A write with both lane strobes low (`cpu_rw` = 0) stores all 16 bits of `cpu_wdata` in the register chosen by `cpu_addr`.
- R3: In a write, `cpu_uds_n` low enables bits 15:8 and `cpu_lds_n` low enables bits 7:0. A lane whose strobe is high keeps its old value.
- R4: A read (`cpu_rw` = 1) presents the addressed register on `cpu_rdata` when the acknowledge asserts. The value stays unchanged for as long as `cpu_ack_n` stays low.
- R5: Suppose strobe and select go low between two rising edges of the fast clock. Then `cpu_ack_n` goes low on the third rising edge after that.
- R6: `cpu_ack_n` stays low while the strobe is held low. After the strobe is released it is high again within two fast clock edges.
- R7: Two accesses separated by a strobe gap of one fast clock are each acknowledged and each take effect, as in the two halves of a split 32-bit write.
- R8: A single strobe performs exactly one access. Changing `cpu_wdata` while the strobe is still held after the acknowledge has no effect on the register.
- R9: When `cpu_cs_n` is high, the address strobe produces no acknowledge and no register write.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_cs_n | input | 1 | Chip select, active low |
| cpu_as_n | input | 1 | Address strobe, active low |
| cpu_uds_n | input | 1 | Upper byte-lane strobe, active low |
| cpu_lds_n | input | 1 | Lower byte-lane strobe, active low |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | ADDR_W | Register index |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, held while acknowledged |
| cpu_ack_n | output | 1 | Acknowledge, active low, level-held |

## Verification
The main access path is exercised four ways: with long isolated strobes, with back-to-back strobes that have a one-clock gap, with a held strobe and changing data, and with a random mix of reads, writes and lane masks. Long isolated strobes set the exact acknowledge latency and the release latency. One-clock gaps distinguish a design that sees the second edge from one that misses it and stalls. Held strobes with changing data expose repeated accesses. The random mix, checked against a reference copy of the bank, catches lane-mask and addressing errors.

// File: rtl/bridge_pkg.sv
// Shared types for the bus bridge.
package bridge_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_HOLD} bstate_t;

    // Registered control view, active-high.
    typedef struct packed {
        logic req;   // select and strobe both active
        logic rd;    // read cycle
        logic upper; // upper lane enabled
        logic lower; // lower lane enabled
    } ctl_t;
endpackage

// File: rtl/bridge_insync.sv
// Register chain for control inputs in the fast domain.
// Assumes inputs are idle-high; reset loads the idle level.
module bridge_insync #(
    parameter int W      = 5,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one register stage along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[s] <= '1;
                else if (s == 0)
                    chain[s] <= din;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/bridge_regbank.sv
// Peripheral register bank with per-byte write enables and combinational read.
// Assumes DATA_W is a multiple of 8.
module bridge_regbank #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 16,
    localparam int ADDR_W  = $clog2(NUM_REGS),
    localparam int BYTES   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BYTES-1:0]  be,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            for (genvar b = 0; b < BYTES; b++) begin : g_byte
                // Update one byte lane of one register.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        regs[r][b*8 +: 8] <= '0;
                    else if (we && be[b] && addr == ADDR_W'(r))
                        regs[r][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
        end
    endgenerate

    // Read mux.
    assign rdata = regs[addr];

    // R8
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);
endmodule

// File: rtl/bridge_ctrl.sv
// Access sequencer: starts one bank access for each inactive-to-active change
// of the registered request, holds the acknowledge until release.
// Assumes address and write data are stable while the strobe is active.
module bridge_ctrl
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    localparam int BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic              bank_we,
    output logic [BYTES-1:0]  bank_be,
    output logic [ADDR_W-1:0] bank_addr,
    output logic [DATA_W-1:0] bank_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack
);
    bstate_t           state;
    logic              rd_q;
    logic [BYTES-1:0]  be_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              ack_q;

    // Sequence each access and drive the registered acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rd_q    <= 1'b1;
            be_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            ack_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (ctl.req) begin
                    state   <= ST_ACCESS;
                    rd_q    <= ctl.rd;
                    be_q    <= {ctl.upper, ctl.lower};
                    addr_q  <= bus_addr;
                    wdata_q <= bus_wdata;
                end
                ST_ACCESS: begin
                    if (rd_q) rdata_q <= bank_rdata;
                    if (ctl.req) begin
                        state <= ST_HOLD;
                        ack_q <= 1'b1;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_HOLD: if (!ctl.req) begin
                    state <= ST_IDLE;
                    ack_q <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bank strobes come from the captured access.
    always_comb begin
        bank_we    = (state == ST_ACCESS) && !rd_q;
        bank_be    = be_q;
        bank_addr  = addr_q;
        bank_wdata = wdata_q;
    end

    assign rdata = rdata_q;
    assign ack   = ack_q;

    // R6
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ctl.req) |=> ack);

    // R4
    rdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack)) |-> $stable(rdata));
endmodule

// File: rtl/bus_xdomain_bridge.sv
// Top: registers CPU-side control into the fast domain, sequences accesses
// into the register bank and returns a level-held active-low acknowledge.
// Assumes the fast clock runs at twice the CPU clock rate.
module bus_xdomain_bridge
    import bridge_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 1,
    localparam int ADDR_W     = $clog2(NUM_REGS),
    localparam int DATA_W     = 16,
    localparam int BYTES      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_cs_n,
    input  logic              cpu_as_n,
    input  logic              cpu_uds_n,
    input  logic              cpu_lds_n,
    input  logic              cpu_rw,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack_n
);
    logic [4:0]        sync_out;
    ctl_t              ctl;
    logic              bank_we;
    logic [BYTES-1:0]  bank_be;
    logic [ADDR_W-1:0] bank_addr;
    logic [DATA_W-1:0] bank_wdata;
    logic [DATA_W-1:0] bank_rdata;
    logic              ack;

    bridge_insync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cpu_cs_n, cpu_as_n, cpu_uds_n, cpu_lds_n, ~cpu_rw}),
        .dout (sync_out)
    );

    // Decode the registered controls into active-high form.
    always_comb begin
        ctl.req   = !sync_out[4] && !sync_out[3];
        ctl.upper = !sync_out[2];
        ctl.lower = !sync_out[1];
        ctl.rd    = !sync_out[0];
    end

    bridge_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .bus_addr  (cpu_addr),
        .bus_wdata (cpu_wdata),
        .bank_rdata(bank_rdata),
        .bank_we   (bank_we),
        .bank_be   (bank_be),
        .bank_addr (bank_addr),
        .bank_wdata(bank_wdata),
        .rdata     (cpu_rdata),
        .ack       (ack)
    );

    bridge_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (bank_we),
        .be   (bank_be),
        .addr (bank_addr),
        .wdata(bank_wdata),
        .rdata(bank_rdata)
    );

    assign cpu_ack_n = !ack;

    // R1
    reset_ack_chk: assert property (@(posedge clk)
        !rst_n |=> cpu_ack_n);

    // R6
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_as_n) && cpu_as_n) |=> cpu_ack_n);

    // R9
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_cs_n) && cpu_cs_n) |=> cpu_ack_n);
endmodule

// File: tb/bus_xdomain_bridge_bench.sv
module bus_xdomain_bridge_bench;
    localparam int NREG = 16;
    localparam int AW   = $clog2(NREG);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_cs_n = 1'b1, cpu_as_n = 1'b1, cpu_uds_n = 1'b1, cpu_lds_n = 1'b1;
    logic          cpu_rw = 1'b1;
    logic [AW-1:0] cpu_addr = '0;
    logic [15:0]   cpu_wdata = '0;
    logic [15:0]   cpu_rdata;
    logic          cpu_ack_n;

    int total = 0, fails = 0;
    logic [15:0] refm [NREG];
    bit ack_lost, rd_unstable;

    always #10 clk = ~clk;

    bus_xdomain_bridge #(.NUM_REGS(NREG)) u_bus_xdomain_bridge (
        .clk(clk), .rst_n(rst_n), .cpu_cs_n(cpu_cs_n), .cpu_as_n(cpu_as_n),
        .cpu_uds_n(cpu_uds_n), .cpu_lds_n(cpu_lds_n), .cpu_rw(cpu_rw),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ack_n(cpu_ack_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus cycle. be[1]=upper lane, be[0]=lower lane.
    // fast=1 releases and returns at once (one-clock gap to the next cycle).
    task automatic cycle(input logic rd, input int addr, input logic [15:0] wd,
                         input logic [1:0] be, input int hold, input bit scramble,
                         input bit fast, output logic [15:0] rdv, output int lat,
                         output bit acked, output bit rel_ok);
        @(negedge clk);
        cpu_addr = AW'(addr); cpu_wdata = wd; cpu_rw = rd;
        cpu_uds_n = !be[1]; cpu_lds_n = !be[0]; cpu_cs_n = 1'b0; cpu_as_n = 1'b0;
        lat = 0; acked = 0; rel_ok = 1;
        while (!acked && lat < 40) begin
            @(negedge clk); lat++;
            if (!cpu_ack_n) acked = 1;
        end
        rdv = cpu_rdata;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (cpu_ack_n) ack_lost = 1;
            if (cpu_rdata !== rdv) rd_unstable = 1;
            if (scramble) cpu_wdata = ~wd ^ 16'(i);
        end
        cpu_as_n = 1'b1; cpu_cs_n = 1'b1; cpu_uds_n = 1'b1; cpu_lds_n = 1'b1;
        if (!rd && acked) begin
            if (be[1]) refm[addr][15:8] = wd[15:8];
            if (be[0]) refm[addr][7:0]  = wd[7:0];
        end
        if (!fast) begin
            @(negedge clk);
            @(negedge clk);
            rel_ok = cpu_ack_n;
        end
    endtask

    task automatic rd_check(input int addr, input string tag);
        logic [15:0] v; int l; bit a, r;
        cycle(1'b1, addr, 16'h0, 2'b11, 1, 0, 0, v, l, a, r);
        check(a && v === refm[addr], tag, v, refm[addr]);
    endtask

    task automatic t_reset;
        check(cpu_ack_n === 1'b1, "R1 ack idle after reset", cpu_ack_n, 1);
        rd_check(0, "R1 reg0 zero");
        rd_check(NREG-1, "R1 last reg zero");
    endtask

    task automatic t_word_latency;
        logic [15:0] v; int l; bit a, r;
        cycle(1'b0, 3, 16'hBEEF, 2'b11, 4, 0, 0, v, l, a, r);
        check(l == 3, "R5 ack latency", l, 3);
        check(r, "R6 ack released within two clocks", r, 1);
        rd_check(3, "R2 full word write");
    endtask

    task automatic t_lanes;
        logic [15:0] v; int l; bit a, r;
        cycle(1'b0, 5, 16'h1234, 2'b11, 0, 0, 0, v, l, a, r);
        cycle(1'b0, 5, 16'hAB00, 2'b10, 0, 0, 0, v, l, a, r);
        rd_check(5, "R3 upper lane only");
        cycle(1'b0, 5, 16'h00CD, 2'b01, 0, 0, 0, v, l, a, r);
        rd_check(5, "R3 lower lane only");
    endtask

    task automatic t_read_hold;
        logic [15:0] v; int l; bit a, r;
        ack_lost = 0; rd_unstable = 0;
        cycle(1'b1, 5, 16'h0, 2'b11, 8, 0, 0, v, l, a, r);
        check(v === refm[5], "R4 read value", v, refm[5]);
        check(!rd_unstable, "R4 rdata stable during ack", rd_unstable, 0);
        check(!ack_lost, "R6 ack held while strobe low", ack_lost, 0);
    endtask

    task automatic t_split;
        logic [15:0] v; int l1, l2; bit a1, a2, r;
        cycle(1'b0, 8, 16'hCAFE, 2'b11, 0, 0, 1, v, l1, a1, r);
        cycle(1'b0, 9, 16'hF00D, 2'b11, 0, 0, 1, v, l2, a2, r);
        check(a1 && a2, "R7 both halves acknowledged", {a1, a2}, 2'b11);
        rd_check(8, "R7 first half stored");
        rd_check(9, "R7 second half stored");
    endtask

    task automatic t_single;
        logic [15:0] v; int l; bit a, r;
        cycle(1'b0, 11, 16'h5A5A, 2'b11, 10, 1, 0, v, l, a, r);
        rd_check(11, "R8 late data change ignored");
    endtask

    task automatic t_deselect;
        bit seen = 0;
        @(negedge clk);
        cpu_addr = AW'(12); cpu_wdata = 16'h7777; cpu_rw = 1'b0;
        cpu_uds_n = 1'b0; cpu_lds_n = 1'b0; cpu_cs_n = 1'b1; cpu_as_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!cpu_ack_n) seen = 1;
        end
        cpu_as_n = 1'b1; cpu_uds_n = 1'b1; cpu_lds_n = 1'b1;
        check(!seen, "R9 no ack when deselected", seen, 0);
        rd_check(12, "R9 register unchanged");
    endtask

    task automatic t_random;
        logic [15:0] v; int l; bit a, r; int bad = 0;
        for (int n = 0; n < 60; n++) begin
            int addr = $urandom_range(NREG-1);
            logic rd = $urandom_range(1) == 1;
            logic [1:0] be = 2'($urandom_range(3));
            logic [15:0] wd = 16'($urandom);
            logic [15:0] exp = refm[addr];
            bit fast = $urandom_range(1) == 1;
            cycle(rd, addr, wd, be, $urandom_range(2), 0, fast, v, l, a, r);
            if (!a || l != 3 || (rd && v !== exp)) bad++;
        end
        check(bad == 0, "R7 random mix all acknowledged and correct", bad, 0);
        for (int k = 0; k < NREG; k++) rd_check(k, "R2 bank matches model");
    endtask

    initial begin
        for (int k = 0; k < NREG; k++) refm[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_latency();
        t_lanes();
        t_read_hold();
        t_split();
        t_single();
        t_deselect();
        t_random();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule